// File: doc/BRIEF.md
# Chain Conversion Readback Sequencer

This block runs one complete convert-and-collect cycle over a daisy chain of one to eight battery monitor devices. It talks to them through a 32-bit word-transfer port. Each word is one full-duplex transfer on a serial master that answers each request with a done pulse and the word it received. A `start` pulse triggers the cycle. The block then issues two broadcast writes. The first points every device's read register at the first cell-voltage channel. The second starts a conversion on chip-select and asks every device to return all of its results.

After the writes, the block waits for the conversion to finish. The wait is worked out from the acquisition-time code, the averaging code and the chain length, and it is counted in microsecond ticks made by an internal clock divider. The block then clocks out twelve result frames per device. Each received frame has its CRC checked. Each good frame is put out on a result stream, one cycle after it arrives and before the next transfer is requested.

The results of the six cell channels of each device are added into a sum. That sum is published when the cycle ends cleanly. If any frame fails its CRC, the cycle ends at once with an error and the previous sum is kept.

Top module: `chain_readback_seq`

## Requirements
- R1: While in reset and right after it, `xfer_req`, `res_valid`, `cycle_done` and `cycle_err` are 0 and `cell_sum` is 0.
- R2: The first transfer after an accepted `start` sends the pointer write. Its fields are:
  - bits [31:27] = 0
  - bits [26:21] = 0x1C
  - bits [20:13] = 0x00
  - bit 12 = 1
  - bit 11 = 0
  - bits [10:3] = CRC
  - bits [2:0] = 3'b010

  The CRC is bits [31:11], taken as a polynomial, reduced modulo x^8+x^5+x^3+x^2+x+1. `xfer_tx` stays stable while `xfer_req` waits for `xfer_done`.
- R3: The second transfer is the control write. It is laid out the same way, with bits [26:21] = 0x0D and bits [20:13] = 0x08 | (avg_code << 1).
- R4: The first read is requested exactly k·CLK_PER_US cycles after the clock edge that accepts the control write's `xfer_done`. Here k = ceil(T/1000) + 5 and T = (tA + 695)·12·2^avg_code − tA + (D − 1)·250. tA is 465, 1010, 1460 or 1890 for acq_code 0 to 3, and D is the effective device count.
- R5: A clean cycle makes exactly D·12 read transfers, each sending 0xF800030A. D is `num_dev`, except that 0 is taken as 1 and any value above MAX_DEV is taken as MAX_DEV.
- R6: A frame that passes its CRC appears the cycle after its `xfer_done`, with `res_valid` = 1 and `xfer_req` = 0. It carries:
  - `res_idx` = its read number, counted from 0
  - `res_frame` = the whole frame
  - `res_chan` = frame bits [26:23]
  - `res_data` = frame bits [22:11]

  Frames appear in order, and the next read is not requested before this.
- R7: A received frame passes when its bits [9:2] equal its bits [31:10] reduced modulo the same polynomial. When a frame fails, the cycle ends the next cycle with `cycle_done` = `cycle_err` = 1. The failing frame is not put out, no further transfers are made and `cell_sum` keeps its previous value.
- R8: `cell_sum` changes only in the `cycle_done` cycle of a clean cycle. It then holds the sum of `res_data` over the frames whose channel field is 5 or less.
- R9: `start` is ignored except when the block is idle, and this includes the `cycle_done` cycle.
- R10: `num_dev`, `acq_code` and `avg_code` are sampled only on an accepted `start`. Changing them later has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one cycle (taken only when idle) |
| num_dev | input | 4 | Devices in the chain |
| acq_code | input | 2 | Acquisition-time code |
| avg_code | input | 2 | Averaging code |
| xfer_req | output | 1 | Word transfer requested, held until done |
| xfer_tx | output | 32 | Word to send |
| xfer_done | input | 1 | Transfer finished, `xfer_rx` valid |
| xfer_rx | input | 32 | Word received |
| res_valid | output | 1 | Result frame valid |
| res_idx | output | IDXW | Frame number within the cycle |
| res_frame | output | 32 | Raw received frame |
| res_chan | output | 4 | Channel field of the frame |
| res_data | output | 12 | 12-bit result of the frame |
| cell_sum | output | SUMW | Sum of cell-channel results of the last clean cycle |
| cycle_done | output | 1 | One-cycle end-of-cycle pulse |
| cycle_err | output | 1 | With `cycle_done`: the cycle was aborted by a CRC failure |

## Verification
Two functions can fall in the same cycle. The first is the end-of-cycle pulse, which can coincide with a fresh `start`. The bench raises `start` exactly in the `cycle_done` cycle and judges that no transfer follows. The second is the CRC check on the final frame, which lands in the cycle that would otherwise publish the sum. The bench corrupts the last frame of a chain and judges that `cycle_err` rises, no frame is put out and `cell_sum` keeps the previous clean value.

// File: rtl/chain_readback_seq.sv
module chain_readback_seq #(
  parameter int MAX_DEV    = 8,
  parameter int CLK_PER_US = 100,
  localparam int FPD  = 12,
  localparam int NFR  = MAX_DEV * FPD,
  localparam int IDXW = $clog2(NFR),
  localparam int SUMW = $clog2(MAX_DEV * 6 * 4095 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      num_dev,
  input  logic [1:0]      acq_code,
  input  logic [1:0]      avg_code,
  output logic            xfer_req,
  output logic [31:0]     xfer_tx,
  input  logic            xfer_done,
  input  logic [31:0]     xfer_rx,
  output logic            res_valid,
  output logic [IDXW-1:0] res_idx,
  output logic [31:0]     res_frame,
  output logic [3:0]      res_chan,
  output logic [11:0]     res_data,
  output logic [SUMW-1:0] cell_sum,
  output logic            cycle_done,
  output logic            cycle_err
);
  localparam int NSW  = $clog2(2585 * 96 + MAX_DEV * 250 + 6000);
  localparam int DIVW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [31:0] RD_WORD = 32'hF800030A;

  typedef enum logic [2:0] {S_IDLE, S_WPTR, S_WCTL, S_WAIT, S_READ, S_EMIT, S_FIN} st_t;

  function automatic logic [7:0] crc_rem(input logic [21:0] v);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 21; i >= 0; i--)
      r = {r[6:0], v[i]} ^ (r[7] ? 8'h2F : 8'h00);
    return r;
  endfunction

  function automatic logic [31:0] mk_write(input logic [5:0] ra, input logic [7:0] val);
    logic [20:0] body;
    body = {5'd0, ra, val, 1'b1, 1'b0};
    return {body, crc_rem({1'b0, body}), 3'b010};
  endfunction

  st_t             state;
  logic [1:0]      avg_q;
  logic [NSW-1:0]  tgt_q, el_ns;
  logic [DIVW-1:0] div_cnt;
  logic [IDXW-1:0] idx, last_q;
  logic [31:0]     frame_q;
  logic [SUMW-1:0] acc, sum_q;
  logic            err_q;

  logic [3:0]      nd_eff;
  logic [NSW-1:0]  tacq, conv_ns, tgt_next;
  logic [SUMW-1:0] add;
  logic            crc_ok, tick;

  assign nd_eff = (num_dev == 4'd0) ? 4'd1 :
                  (int'(num_dev) > MAX_DEV) ? 4'(MAX_DEV) : num_dev;

  always_comb begin
    case (acq_code)
      2'd0:    tacq = NSW'(465);
      2'd1:    tacq = NSW'(1010);
      2'd2:    tacq = NSW'(1460);
      default: tacq = NSW'(1890);
    endcase
    conv_ns  = ((tacq + NSW'(695)) * NSW'(FPD)) << avg_code;
    tgt_next = conv_ns - tacq + NSW'(nd_eff - 4'd1) * NSW'(250) + NSW'(5000);
  end

  assign crc_ok = crc_rem(xfer_rx[31:10]) == xfer_rx[9:2];
  assign tick   = div_cnt == DIVW'(CLK_PER_US - 1);
  assign add    = (frame_q[26:23] <= 4'd5) ? SUMW'(frame_q[22:11]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      avg_q   <= '0;
      tgt_q   <= '0;
      el_ns   <= '0;
      div_cnt <= '0;
      idx     <= '0;
      last_q  <= '0;
      frame_q <= '0;
      acc     <= '0;
      sum_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          avg_q  <= avg_code;
          tgt_q  <= tgt_next;
          last_q <= IDXW'(int'(nd_eff) * FPD - 1);
          idx    <= '0;
          acc    <= '0;
          err_q  <= 1'b0;
          state  <= S_WPTR;
        end
        S_WPTR: if (xfer_done) state <= S_WCTL;
        S_WCTL: if (xfer_done) begin
          div_cnt <= '0;
          el_ns   <= '0;
          state   <= S_WAIT;
        end
        S_WAIT: begin
          if (tick) begin
            div_cnt <= '0;
            el_ns   <= el_ns + NSW'(1000);
            if (el_ns + NSW'(1000) >= tgt_q) state <= S_READ;
          end else begin
            div_cnt <= div_cnt + DIVW'(1);
          end
        end
        S_READ: if (xfer_done) begin
          if (crc_ok) begin
            frame_q <= xfer_rx;
            state   <= S_EMIT;
          end else begin
            err_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_EMIT: begin
          acc <= acc + add;
          if (idx == last_q) begin
            sum_q <= acc + add;
            state <= S_FIN;
          end else begin
            idx   <= idx + IDXW'(1);
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer_req   = (state == S_WPTR) || (state == S_WCTL) || (state == S_READ);
  assign xfer_tx    = (state == S_WPTR) ? mk_write(6'h1C, 8'h00) :
                      (state == S_WCTL) ? mk_write(6'h0D, {4'b0000, 1'b1, avg_q, 1'b0}) :
                      RD_WORD;
  assign res_valid  = state == S_EMIT;
  assign res_idx    = idx;
  assign res_frame  = frame_q;
  assign res_chan   = frame_q[26:23];
  assign res_data   = frame_q[22:11];
  assign cell_sum   = sum_q;
  assign cycle_done = state == S_FIN;
  assign cycle_err  = (state == S_FIN) && err_q;

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_tx));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_idx <= last_q);

  assert_emit_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ) && xfer_done && crc_ok |=> res_valid && !xfer_req);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);

  assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ) && xfer_done && !crc_ok |=> cycle_done && cycle_err);

  assert_sum_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cell_sum) |-> cycle_done && !cycle_err);

  assert_fin_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && start |=> !xfer_req);
endmodule

// File: tb/chain_readback_seq_tb.sv
module chain_readback_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int US_DIV     = 3;
  localparam logic [31:0] RD_WORD = 32'hF800030A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  num_dev = 4'd1;
  logic [1:0]  acq_code = 2'd0, avg_code = 2'd0;
  logic        xfer_req, xfer_done = 1'b0;
  logic [31:0] xfer_tx, xfer_rx = 32'd0;
  logic        res_valid;
  logic [6:0]  res_idx;
  logic [31:0] res_frame;
  logic [3:0]  res_chan;
  logic [11:0] res_data;
  logic [17:0] cell_sum;
  logic        cycle_done, cycle_err;

  chain_readback_seq #(.MAX_DEV(8), .CLK_PER_US(US_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_dev(num_dev),
    .acq_code(acq_code), .avg_code(avg_code),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .res_valid(res_valid), .res_idx(res_idx), .res_frame(res_frame),
    .res_chan(res_chan), .res_data(res_data), .cell_sum(cell_sum),
    .cycle_done(cycle_done), .cycle_err(cycle_err));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [11:0] dat [96];
  logic [31:0] rxf [96];
  logic [31:0] tx_log [2];
  int n_xfer, n_reads, emit_cnt, lat, wr_end_cyc, rd_start_cyc, bad_tx;
  int prev_sum = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_tab(input logic [7:0] x);
    logic [7:0] c = x;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] tb_crc(input logic [31:0] v);
    logic [7:0] c;
    c = tb_tab(v[23:16]);
    c = tb_tab(c ^ v[15:8]);
    return c ^ v[7:0];
  endfunction

  function automatic logic [31:0] tb_write(input logic [5:0] ra, input logic [7:0] val);
    logic [31:0] w;
    w = {5'd0, ra, val, 1'b1, 1'b0, 8'h00, 3'b010};
    w[10:3] = tb_crc(w >> 11);
    return w;
  endfunction

  initial begin : link_model
    logic [31:0] t, rx;
    forever begin
      @(negedge clk);
      if (xfer_req) begin
        t = xfer_tx;
        rx = 32'd0;
        if (n_xfer < 2) tx_log[n_xfer] = t;
        if (n_xfer == 2) rd_start_cyc = cyc;
        if (n_xfer >= 2) begin
          if (t != RD_WORD) bad_tx++;
          if (n_reads < 96) rx = rxf[n_reads];
          n_reads++;
        end
        repeat (lat) @(negedge clk);
        xfer_rx = rx;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        if (n_xfer == 1) wr_end_cyc = cyc;
        n_xfer++;
      end
    end
  end

  initial begin : emit_monitor
    forever begin
      @(negedge clk);
      if (res_valid) begin
        chk(res_idx == 7'(emit_cnt) && res_chan == 4'(emit_cnt % 12) &&
            res_data == dat[emit_cnt] && res_frame == rxf[emit_cnt],
            "R6 frame fields", longint'(res_data), longint'(dat[emit_cnt]));
        chk(!xfer_req && n_reads == emit_cnt + 1, "R6 emit before next read",
            longint'(n_reads), longint'(emit_cnt + 1));
        emit_cnt++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_cycle(input int nd_in, input int acq, input int avg, input int bad,
                           input bit start_at_fin);
    int nd, nfr, tac, tns, k, exp_sum, rd_snap;
    logic [31:0] f;
    bit err_s;
    int sum_s;
    nd = (nd_in == 0) ? 1 : ((nd_in > 8) ? 8 : nd_in);
    nfr = nd * 12;
    exp_sum = 0;
    for (int i = 0; i < nfr; i++) begin
      dat[i] = 12'($urandom);
      f = {5'(i / 12), 4'(i % 12), dat[i], 1'($urandom), 8'h00, 2'b00};
      f[9:2] = tb_crc(f >> 10);
      if (i == bad) f[2] = ~f[2];
      rxf[i] = f;
      if (i % 12 <= 5) exp_sum += int'(dat[i]);
    end
    n_xfer = 0; n_reads = 0; emit_cnt = 0; bad_tx = 0;
    lat = int'($urandom % 4);
    @(negedge clk);
    start = 1'b1; num_dev = 4'(nd_in); acq_code = 2'(acq); avg_code = 2'(avg);
    @(negedge clk);
    start = 1'b0;
    num_dev = 4'($urandom); acq_code = 2'($urandom); avg_code = 2'($urandom);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!cycle_done) @(negedge clk);
    err_s = cycle_err;
    sum_s = int'(cell_sum);
    rd_snap = n_reads;
    if (start_at_fin) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(!xfer_req && n_reads == rd_snap, "R9 start in done cycle ignored",
          longint'(n_reads), longint'(rd_snap));
    end else begin
      @(negedge clk);
    end
    case (acq)
      0: tac = 465;
      1: tac = 1010;
      2: tac = 1460;
      default: tac = 1890;
    endcase
    tns = (tac + 695) * 12 * (1 << avg) - tac + (nd - 1) * 250;
    k = (tns + 999) / 1000 + 5;
    chk(tx_log[0] == tb_write(6'h1C, 8'h00), "R2 pointer write",
        longint'(tx_log[0]), longint'(tb_write(6'h1C, 8'h00)));
    chk(tx_log[1] == tb_write(6'h0D, 8'h08 | 8'(avg << 1)), "R3 control write R10",
        longint'(tx_log[1]), longint'(tb_write(6'h0D, 8'h08 | 8'(avg << 1))));
    chk(rd_start_cyc - wr_end_cyc == k * US_DIV, "R4 readback delay R10",
        longint'(rd_start_cyc - wr_end_cyc), longint'(k * US_DIV));
    chk(n_reads == ((bad >= 0) ? bad + 1 : nfr) && bad_tx == 0, "R5 read count R10",
        longint'(n_reads), longint'((bad >= 0) ? bad + 1 : nfr));
    chk(emit_cnt == ((bad >= 0) ? bad : nfr), "R6 frames emitted",
        longint'(emit_cnt), longint'((bad >= 0) ? bad : nfr));
    chk(err_s == (bad >= 0), "R7 error flag", longint'(err_s), longint'(bad >= 0));
    if (bad < 0) begin
      chk(sum_s == exp_sum, "R8 cell sum", longint'(sum_s), longint'(exp_sum));
      prev_sum = exp_sum;
    end else begin
      chk(sum_s == prev_sum, "R7 sum kept on error", longint'(sum_s), longint'(prev_sum));
    end
  endtask

  initial begin : stim
    int r;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(!xfer_req && !res_valid && !cycle_done && !cycle_err && cell_sum == 0,
        "R1 state in reset", longint'({xfer_req, res_valid, cycle_done, cycle_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xfer_req && !res_valid && !cycle_done && !cycle_err && cell_sum == 0,
        "R1 state after reset", longint'(cell_sum), 0);
    run_cycle(1, 0, 0, -1, 1'b0);
    run_cycle(8, 3, 3, -1, 1'b0);
    run_cycle(0, 1, 2, -1, 1'b0);
    run_cycle(12, 2, 1, -1, 1'b0);
    run_cycle(2, 1, 1, 0, 1'b0);
    run_cycle(3, 0, 2, 35, 1'b1);
    run_cycle(4, 2, 0, -1, 1'b1);
    for (int n = 0; n < 6; n++) begin
      r = int'($urandom % 3);
      run_cycle(int'($urandom % 8) + 1, int'($urandom % 4), int'($urandom % 4),
                (r == 0) ? int'($urandom % 12) : -1, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule